// File: doc/BRIEF.md
# Synchronous Burst SRAM with Selectable Output Path

This block is a synthesizable behavioural model of a small single-port synchronous SRAM. It holds 32-bit words and can write single bytes. Every command, address and data input is captured on the rising clock edge. A command starts when the load strobe is high and all three chip enables are in their active state. After that, a session carries on: a 2-bit burst counter makes each following address, and it steps in either linear or interleaved order. The word path out of the array can take one of two forms, chosen by a static mode input. In registered mode, the word passes through one more output register. In flow-through mode, it skips that register. Turning the device off follows the read pipeline, so the data bus stays driven for one extra cycle after a deselect.

Writes go byte by byte, under a byte-write enable with four lane strobes. A global write stores the whole word whatever the lane strobes say. Two inputs act at once, without waiting for a clock edge. The output enable gates the bus. The sleep input ignores every command at each edge while it is high, turns the bus off and keeps the array contents. The output bus is shown as a data vector plus a drive flag. When the drive flag is low, the data vector reads zero; this stands in for a high-impedance bus.

Top module: `sync_burst_sram`

## Requirements
- R1: A load cycle selects the device only when `ce_a_i`=1, `ce_b_i`=1 and `ce_n_i`=0. If any of the three is inactive, the load cycle is a deselect and starts no read or write.
- R2: With `pipe_mode_i`=0 (flow-through), the word read by a command sampled at edge k is driven on `rdata_o` with `drive_o`=1 in the cycle that follows edge k.
- R3: With `pipe_mode_i`=1 (registered), the same word is driven only in the cycle that follows edge k+1.
- R4: Deselect is held one cycle. A deselect sampled at edge k, right after a read, keeps the read word driven for one extra cycle. The bus turns off after edge k+2 in registered mode and after edge k+1 in flow-through mode.
- R5: A byte write occurs when `bw_en_i`=1 and `bs_i`≠0. Strobe bit i updates only bits [8i+7:8i] of the addressed word.
- R6: When `gw_i`=1, all four bytes are written, whatever `bw_en_i` and `bs_i` say.
- R7: A write is complete at the edge that samples it. A read of the same address at the next edge returns the new word.
- R8: A load with the device selected starts a burst at `addr_i`, with offset 0. While the session stays open, each cycle with `adv_i`=1 and `load_i`=0 steps the 2-bit offset by one, which wraps. A cycle with `adv_i`=0 repeats the current address. With `linear_i`=1 the low two address bits are base+offset mod 4. With `linear_i`=0 they are base XOR offset. The upper address bits are fixed.
- R9: While `sleep_i`=1, `drive_o` is 0 at once. Every command sampled while it is high is ignored. Array contents stay as they were across sleep.
- R10: `oe_i` acts without waiting for a clock edge. `drive_o` is 0 whenever `oe_i`=0, and `rdata_o` is zero whenever `drive_o`=0.
- R11: After synchronous reset, `drive_o`=0, `rdata_o`=0 and no session is open.
- R12: A write command never drives the bus in the output slot that a read would have used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| pipe_mode_i | input | 1 | Static: 1 = registered output, 0 = flow-through |
| linear_i | input | 1 | Static: 1 = linear burst order, 0 = interleaved |
| ce_a_i | input | 1 | Chip enable, active high |
| ce_b_i | input | 1 | Chip enable, active high |
| ce_n_i | input | 1 | Chip enable, active low |
| load_i | input | 1 | Load a new address and start a session |
| adv_i | input | 1 | Step the burst counter within a session |
| addr_i | input | ADDR_W | Word address sampled on load |
| gw_i | input | 1 | Global write, all bytes |
| bw_en_i | input | 1 | Byte-write enable |
| bs_i | input | 4 | Byte-lane strobes |
| wdata_i | input | 32 | Write word |
| oe_i | input | 1 | Output enable, acts without a clock edge |
| sleep_i | input | 1 | Sleep, acts without a clock edge, contents kept |
| rdata_o | output | 32 | Read word, zero when not driven |
| drive_o | output | 1 | Bus drive flag |

## Verification
The assertions check, on every cycle, the gating by output enable and sleep, the zero value on an undriven bus, and the bus turning off after reset. They also check the timing of the bus for load commands: the cycle in which a read first drives, the one-cycle hold after a deselect, the bus being off after two deselects in a row, and the silent output slot after a write. Only the bench scenarios can show what the data holds. This covers byte-lane merging, global-write override, burst address order in both modes, read-after-write, and contents kept across sleep. A reference model in the bench compares every cycle of a randomized command mix.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned LANE_W  = 8;
    localparam int unsigned LANES   = WORD_W / LANE_W;
    localparam int unsigned BURST_W = 2;

    // Kind of work an edge performs; OFF covers deselect, idle and sleep
    typedef enum logic [1:0] {
        SLOT_OFF = 2'd0,
        SLOT_RD  = 2'd1,
        SLOT_WR  = 2'd2
    } slot_e;

    typedef struct packed {
        slot_e              kind;
        logic [LANES-1:0]   mask;
    } cmd_t;

    // Low address bits of the current beat
    function automatic logic [BURST_W-1:0] burst_lo(
        input logic [BURST_W-1:0] base,
        input logic [BURST_W-1:0] offs,
        input logic               linear
    );
        return linear ? (base + offs) : (base ^ offs);
    endfunction

    // Lanes written this cycle; global write wins over the strobes
    function automatic logic [LANES-1:0] lane_mask(
        input logic             gw,
        input logic             bw_en,
        input logic [LANES-1:0] strobes
    );
        if (gw)
            return {LANES{1'b1}};
        return bw_en ? strobes : '0;
    endfunction

    // Bus drive decision from the visible slot and the one behind it:
    // a deselect right after a read holds the bus one more cycle
    function automatic logic slot_drives(input slot_e cur, input slot_e prev);
        return (cur == SLOT_RD) || ((cur == SLOT_OFF) && (prev == SLOT_RD));
    endfunction

endpackage

// File: rtl/sbs_cmd_decode.sv
module sbs_cmd_decode
    import sbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             awake_i,
    input  logic             sel_i,
    input  logic             load_i,
    input  logic             adv_i,
    input  logic             gw_i,
    input  logic             bw_en_i,
    input  logic [LANES-1:0] bs_i,
    output cmd_t             cmd_o,
    output logic             start_o,
    output logic             step_o
);

    logic             open_q;
    logic [LANES-1:0] mask;
    logic             is_wr;
    logic             busy;

    assign mask  = lane_mask(gw_i, bw_en_i, bs_i);
    assign is_wr = |mask;

    // A live command: selected load, or a cycle inside an open session
    assign busy    = !rst && awake_i && (load_i ? sel_i : open_q);
    assign start_o = !rst && awake_i && load_i && sel_i;
    assign step_o  = !rst && awake_i && !load_i && open_q && adv_i;

    always_comb begin
        cmd_o.kind = SLOT_OFF;
        cmd_o.mask = '0;
        if (busy) begin
            cmd_o.kind = is_wr ? SLOT_WR : SLOT_RD;
            cmd_o.mask = mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            open_q <= 1'b0;
        else if (awake_i && load_i)
            open_q <= sel_i;
    end

endmodule

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr
    import sbs_pkg::*;
#(
    parameter  int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              linear_i,
    input  logic              start_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0]  base_q;
    logic [ADDR_W-1:0]  base_now;
    logic [BURST_W-1:0] offs_q;
    logic [BURST_W-1:0] offs_now;

    assign base_now = start_i ? addr_i : base_q;

    always_comb begin
        if (start_i)
            offs_now = '0;
        else if (step_i)
            offs_now = offs_q + 1'b1;
        else
            offs_now = offs_q;
    end

    assign addr_o = {base_now[ADDR_W-1:BURST_W],
                     burst_lo(base_now[BURST_W-1:0], offs_now, linear_i)};

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            offs_q <= '0;
        end else begin
            base_q <= base_now;
            offs_q <= offs_now;
        end
    end

endmodule

// File: rtl/sbs_lane_array.sv
module sbs_lane_array
    import sbs_pkg::*;
#(
    parameter  int unsigned DEPTH  = 256,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rd_word_o
);

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [WORD_W-1:0] old_word;
    logic [WORD_W-1:0] merged;

    assign old_word = mem_q[addr_i];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*LANE_W +: LANE_W] = cmd_i.mask[g] ? wdata_i[g*LANE_W +: LANE_W]
                                                          : old_word[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (cmd_i.kind == SLOT_WR)
            mem_q[addr_i] <= merged;
    end

    // Sense register: holds the last word read until the next read
    always_ff @(posedge clk) begin
        if (rst)
            rd_word_o <= '0;
        else if (cmd_i.kind == SLOT_RD)
            rd_word_o <= old_word;
    end

endmodule

// File: rtl/sbs_out_stage.sv
module sbs_out_stage
    import sbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pipe_mode_i,
    input  logic              oe_i,
    input  logic              awake_i,
    input  slot_e             slot_i,
    input  logic [WORD_W-1:0] rd_word_i,
    output logic              drive_o,
    output logic [WORD_W-1:0] data_o
);

    slot_e             s1_q, s2_q, s3_q;
    logic [WORD_W-1:0] out_q;
    logic              want;
    logic [WORD_W-1:0] word;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q  <= SLOT_OFF;
            s2_q  <= SLOT_OFF;
            s3_q  <= SLOT_OFF;
            out_q <= '0;
        end else begin
            s1_q  <= slot_i;
            s2_q  <= s1_q;
            s3_q  <= s2_q;
            out_q <= rd_word_i;
        end
    end

    // Registered mode looks one stage further down the slot pipe
    always_comb begin
        if (pipe_mode_i) begin
            want = slot_drives(s2_q, s3_q);
            word = out_q;
        end else begin
            want = slot_drives(s1_q, s2_q);
            word = rd_word_i;
        end
    end

    assign drive_o = want && oe_i && awake_i;
    assign data_o  = drive_o ? word : '0;

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter  int unsigned DEPTH  = 256,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pipe_mode_i,
    input  logic              linear_i,
    input  logic              ce_a_i,
    input  logic              ce_b_i,
    input  logic              ce_n_i,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              gw_i,
    input  logic              bw_en_i,
    input  logic [LANES-1:0]  bs_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              oe_i,
    input  logic              sleep_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              drive_o
);

    logic              awake;
    logic              sel;
    cmd_t              cmd;
    logic              start;
    logic              step;
    logic [ADDR_W-1:0] beat_addr;
    logic [WORD_W-1:0] rd_word;

    assign awake = !sleep_i;
    assign sel   = ce_a_i && ce_b_i && !ce_n_i;

    sbs_cmd_decode i_decode (
        .clk     (clk),
        .rst     (rst),
        .awake_i (awake),
        .sel_i   (sel),
        .load_i  (load_i),
        .adv_i   (adv_i),
        .gw_i    (gw_i),
        .bw_en_i (bw_en_i),
        .bs_i    (bs_i),
        .cmd_o   (cmd),
        .start_o (start),
        .step_o  (step)
    );

    sbs_burst_ctr #(.ADDR_W(ADDR_W)) i_burst (
        .clk      (clk),
        .rst      (rst),
        .linear_i (linear_i),
        .start_i  (start),
        .step_i   (step),
        .addr_i   (addr_i),
        .addr_o   (beat_addr)
    );

    sbs_lane_array #(.DEPTH(DEPTH)) i_array (
        .clk       (clk),
        .rst       (rst),
        .cmd_i     (cmd),
        .addr_i    (beat_addr),
        .wdata_i   (wdata_i),
        .rd_word_o (rd_word)
    );

    sbs_out_stage i_out (
        .clk         (clk),
        .rst         (rst),
        .pipe_mode_i (pipe_mode_i),
        .oe_i        (oe_i),
        .awake_i     (awake),
        .slot_i      (cmd.kind),
        .rd_word_i   (rd_word),
        .drive_o     (drive_o),
        .data_o      (rdata_o)
    );

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker (
    input logic        clk,
    input logic        rst,
    input logic        pipe_mode_i,
    input logic        ce_a_i,
    input logic        ce_b_i,
    input logic        ce_n_i,
    input logic        load_i,
    input logic        gw_i,
    input logic        bw_en_i,
    input logic [3:0]  bs_i,
    input logic        oe_i,
    input logic        sleep_i,
    input logic [31:0] rdata_o,
    input logic        drive_o
);

    logic picked;
    logic writes;
    logic rd_cmd;
    logic wr_cmd;
    logic off_cmd;

    assign picked  = ce_a_i && ce_b_i && !ce_n_i;
    assign writes  = gw_i || (bw_en_i && (bs_i != 4'd0));
    assign rd_cmd  = load_i && picked && !writes && !sleep_i;
    assign wr_cmd  = load_i && picked && writes && !sleep_i;
    assign off_cmd = load_i && !picked && !sleep_i;

    // R9: sleeping bus is never driven
    p_sleep_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        sleep_i |-> !drive_o);

    // R10: output enable gates the bus; an undriven bus reads zero
    p_oe_gate_r10: assert property (@(posedge clk) disable iff (rst)
        !oe_i |-> !drive_o);
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !drive_o |-> (rdata_o == 32'd0));

    // R11: reset leaves the bus off
    p_reset_off_r11: assert property (@(posedge clk)
        rst |=> !drive_o);

    // R2: flow-through read drives in the next cycle
    p_flow_read_r2: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode_i && rd_cmd) |=> (!oe_i || sleep_i || drive_o));

    // R3: registered read is silent one cycle, then drives
    p_pipe_read_r3: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode_i && rd_cmd) |=> ##1 (!oe_i || sleep_i || drive_o));

    // R4: deselect after a read holds the bus one more cycle
    p_flow_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode_i && off_cmd && $past(rd_cmd)) |=> (!oe_i || sleep_i || drive_o));
    p_pipe_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode_i && off_cmd && $past(rd_cmd))
            |=> ##1 ((!oe_i || sleep_i || drive_o)
                     && (!drive_o || !$past(drive_o) || $stable(rdata_o))));

    // R4: two deselects in a row turn the bus off
    p_flow_off_r4: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode_i && off_cmd && $past(off_cmd)) |=> !drive_o);
    p_pipe_off_r4: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode_i && off_cmd && $past(off_cmd)) |=> ##1 !drive_o);

    // R12: a write leaves its output slot silent
    p_flow_wr_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode_i && wr_cmd) |=> !drive_o);
    p_pipe_wr_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode_i && wr_cmd) |=> ##1 !drive_o);

endmodule

bind sync_burst_sram sbs_checker i_sbs_checker (
    .clk         (clk),
    .rst         (rst),
    .pipe_mode_i (pipe_mode_i),
    .ce_a_i      (ce_a_i),
    .ce_b_i      (ce_b_i),
    .ce_n_i      (ce_n_i),
    .load_i      (load_i),
    .gw_i        (gw_i),
    .bw_en_i     (bw_en_i),
    .bs_i        (bs_i),
    .oe_i        (oe_i),
    .sleep_i     (sleep_i),
    .rdata_o     (rdata_o),
    .drive_o     (drive_o)
);

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;

    localparam int unsigned DEPTH = 256;
    localparam int unsigned AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst;
    logic          pm, lin, ce_a, ce_b, ce_n, ld, adv, gw, bwe, oe, slp;
    logic [AW-1:0] addr;
    logic [3:0]    bs;
    logic [31:0]   wd;
    logic [31:0]   rdata;
    logic          drive;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    // reference model state
    logic [31:0]   mm [DEPTH];
    bit            m_act;
    logic [AW-1:0] m_base;
    logic [1:0]    m_cnt;
    int            k0, k1, k2;   // 0 off, 1 read, 2 write
    logic [31:0]   l1, l2;

    always #2.5 clk = ~clk;

    sync_burst_sram #(.DEPTH(DEPTH)) i_sync_burst_sram (
        .clk(clk), .rst(rst), .pipe_mode_i(pm), .linear_i(lin),
        .ce_a_i(ce_a), .ce_b_i(ce_b), .ce_n_i(ce_n),
        .load_i(ld), .adv_i(adv), .addr_i(addr),
        .gw_i(gw), .bw_en_i(bwe), .bs_i(bs), .wdata_i(wd),
        .oe_i(oe), .sleep_i(slp), .rdata_o(rdata), .drive_o(drive)
    );

    function automatic logic [31:0] fill(input int a);
        return (32'(a) * 32'h0100_0193) ^ 32'hC3A5_0F1E;
    endfunction

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input logic [1:0] c, input logic l);
        logic [1:0] lo;
        lo = l ? (b[1:0] + c) : (b[1:0] ^ c);
        return {b[AW-1:2], lo};
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] m);
        logic [31:0] r;
        for (int i = 0; i < 4; i++)
            r[i*8 +: 8] = m[i] ? n[i*8 +: 8] : o[i*8 +: 8];
        return r;
    endfunction

    function automatic bit drv_of(input int cur, input int prev);
        return (cur == 1) || (cur == 0 && prev == 1);
    endfunction

    task automatic check(input string tag, input logic [32:0] got, input logic [32:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: drive/data got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic expect_word(input string tag, input logic [31:0] w);
        check(tag, {drive, rdata}, {1'b1, w});
    endtask

    task automatic expect_off(input string tag);
        check(tag, {drive, rdata}, 33'd0);
    endtask

    task automatic set_idle();
        ld = 0; adv = 0; ce_a = 1; ce_b = 1; ce_n = 0;
        gw = 0; bwe = 0; bs = 0; addr = '0; wd = '0; slp = 0; oe = 1;
    endtask

    // one clock: model update at the edge, full compare at the falling edge
    task automatic tick(input string tag);
        bit sel, wr;
        int kind;
        logic [AW-1:0] ea;
        logic exp_drv;
        logic [31:0] exp_dat;
        @(posedge clk);
        sel  = ce_a && ce_b && !ce_n;
        wr   = gw || (bwe && (bs != 0));
        kind = 0;
        if (!slp) begin
            if (ld) begin
                m_act = sel;
                if (sel) begin m_base = addr; m_cnt = 0; kind = wr ? 2 : 1; end
            end else if (m_act) begin
                if (adv) m_cnt = m_cnt + 2'd1;
                kind = wr ? 2 : 1;
            end
        end
        ea = exp_addr(m_base, m_cnt, lin);
        k2 = k1; k1 = k0; k0 = kind;
        l2 = l1;
        if (kind == 1) l1 = mm[ea];
        if (kind == 2) mm[ea] = merge(mm[ea], wd, gw ? 4'hF : bs);
        @(negedge clk);
        exp_drv = (pm ? drv_of(k1, k2) : drv_of(k0, k1)) && oe && !slp;
        exp_dat = exp_drv ? (pm ? l2 : l1) : 32'd0;
        check(tag, {drive, rdata}, {exp_drv, exp_dat});
    endtask

    task automatic desel(input string tag);
        set_idle(); ld = 1; ce_a = 0; tick(tag);
    endtask

    task automatic rd_load(input string tag, input int a);
        set_idle(); ld = 1; addr = AW'(a); tick(tag);
    endtask

    task automatic do_reset(input bit pipe, input bit linear);
        set_idle();
        rst = 1; pm = pipe; lin = linear;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_act = 0; m_base = '0; m_cnt = 0;
        k0 = 0; k1 = 0; k2 = 0; l1 = '0; l2 = '0;
        expect_off("R11");
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        rst = 1; pm = 1; lin = 0; set_idle();

        // registered mode: fill, byte write, global write, deselect timing
        do_reset(1'b1, 1'b0);
        for (int a = 0; a < DEPTH; a++) begin
            set_idle(); ld = 1; gw = 1; addr = AW'(a); wd = fill(a); tick("R6");
        end
        set_idle(); ld = 1; addr = 5; bwe = 1; bs = 4'b0101; wd = 32'hAABB_CCDD; tick("R5");
        rd_load("R7", 5);
        desel("R4");
        v = fill(5);
        expect_word("R5", {v[31:24], 8'hBB, v[15:8], 8'hDD});
        set_idle(); ld = 1; addr = 6; gw = 1; bwe = 1; bs = 4'b0001; wd = 32'h1234_5678; tick("R6");
        rd_load("R7", 6);
        desel("R4");
        expect_word("R6", 32'h1234_5678);
        desel("R4"); desel("R4");
        rd_load("R3", 7); expect_off("R3");
        desel("R3");      expect_word("R3", fill(7));
        desel("R4");      expect_word("R4", fill(7));
        desel("R4");      expect_off("R4");

        // flow-through mode: latency, hold, chip enables
        do_reset(1'b0, 1'b0);
        desel("R4"); desel("R4");
        rd_load("R2", 7); expect_word("R2", fill(7));
        desel("R4");      expect_word("R4", fill(7));
        desel("R4");      expect_off("R4");
        for (int p = 0; p < 3; p++) begin
            set_idle(); ld = 1; addr = 8;
            if (p == 0) ce_a = 0; else if (p == 1) ce_b = 0; else ce_n = 1;
            tick("R1"); expect_off("R1");
            desel("R1");
        end
        rd_load("R1", 8); expect_word("R1", fill(8));
        desel("R4"); desel("R4");

        // burst order, interleaved then linear
        rd_load("R8", 8'h11); expect_word("R8", fill(8'h11));
        set_idle(); adv = 1; tick("R8"); expect_word("R8", fill(8'h10));
        set_idle(); adv = 1; tick("R8"); expect_word("R8", fill(8'h13));
        set_idle(); adv = 1; tick("R8"); expect_word("R8", fill(8'h12));
        set_idle();          tick("R8"); expect_word("R8", fill(8'h12));
        set_idle(); adv = 1; tick("R8"); expect_word("R8", fill(8'h11));
        do_reset(1'b0, 1'b1);
        rd_load("R8", 8'h11); expect_word("R8", fill(8'h11));
        set_idle(); adv = 1; tick("R8"); expect_word("R8", fill(8'h12));
        set_idle(); adv = 1; tick("R8"); expect_word("R8", fill(8'h13));
        set_idle(); adv = 1; tick("R8"); expect_word("R8", fill(8'h10));
        desel("R4"); desel("R4");

        // write slot is silent, read-after-write
        set_idle(); ld = 1; addr = 20; gw = 1; wd = 32'hDEAD_BEEF; tick("R12"); expect_off("R12");
        rd_load("R7", 20); expect_word("R7", 32'hDEAD_BEEF);
        desel("R4"); desel("R4");

        // sleep keeps contents and ignores commands
        set_idle(); ld = 1; addr = 30; gw = 1; wd = 32'h0BAD_F00D; tick("R9");
        set_idle(); slp = 1; ld = 1; addr = 30; gw = 1; wd = 32'h1111_2222; tick("R9"); expect_off("R9");
        set_idle(); slp = 1; ld = 1; addr = 30; tick("R9"); expect_off("R9");
        desel("R9");
        rd_load("R9", 30); expect_word("R9", 32'h0BAD_F00D);
        desel("R4"); desel("R4");

        // output enable acts between edges
        set_idle(); oe = 0; ld = 1; addr = 8; tick("R10"); expect_off("R10");
        oe = 1; #1; expect_word("R10", fill(8));
        desel("R4"); desel("R4");

        // random mix in both modes
        for (int m = 0; m < 2; m++) begin
            do_reset(m == 0, m == 1);
            for (int i = 0; i < 3000; i++) begin
                int p, w;
                set_idle();
                ld  = ($urandom_range(0, 99) < 35);
                adv = 1'($urandom_range(0, 1));
                p = $urandom_range(0, 9);
                if (p == 0) ce_a = 0; else if (p == 1) ce_b = 0; else if (p == 2) ce_n = 1;
                w = $urandom_range(0, 3);
                if (w == 0) gw = 1;
                else if (w == 1) begin bwe = 1; bs = 4'($urandom_range(0, 15)); end
                addr = AW'($urandom_range(0, DEPTH - 1));
                wd   = $urandom;
                slp  = ($urandom_range(0, 19) == 0);
                oe   = ($urandom_range(0, 9) != 0);
                tick(pm ? "R3" : "R2");
            end
        end

        // reset in the middle of activity
        rd_load("R2", 9);
        set_idle(); rst = 1; @(posedge clk); @(negedge clk);
        expect_off("R11");
        rst = 0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule